// File: doc/BRIEF.md
# Radix-N Nibble Carry Adjust Unit

This unit is a small 4-bit execution slice for a nibble-oriented processor core. It accepts 13-bit instruction words and carries out two operation families. The first adds one of two 4-bit accumulators, A or B, into A or B in a single cycle. The second adds the carry flag to a nibble held in data memory and corrects the sum to a radix between 1 and 16 that is encoded in the opcode. It writes the corrected nibble back and then advances the pointer register, X or Y, that addressed it. A single instruction can therefore ripple a carry through a multi-digit counter of any base, one digit per instruction.

The unit holds the A/B accumulators, the 16-bit X/Y pointers, the four flags E, I, C and Z, and a small nibble-wide data memory. A preload port lets the surrounding test environment seed registers, flags and memory while the unit is idle. A peek port reads memory without affecting it. A busy/done pair tells the pipeline when a multi-cycle operation is in flight and when it has finished. Any word outside both families is flagged as illegal and changes nothing.

Top module: `nib_radix_exec`

## Requirements
- R1: After a synchronous active-low reset, A, B, X, Y and all four flags read zero, and busy, done and illegal are low.
- R2: Words 0x1970 to 0x1977 are register adds. Bit 2 selects the destination (0 = A, 1 = B) and bit 1 selects the source (0 = A, 1 = B). Bit 0 is ignored. The destination receives the low 4 bits of the sum. C is the binary carry out of bit 3, and Z is set when the 4-bit result is zero.
- R3: A register add is accepted in the cycle that instr_valid is high while the unit is not busy. Its results and a one-cycle done pulse appear after the next clock edge, and busy stays low.
- R4: Words 0x1D10 to 0x1D1F are carry-adds through X and words 0x1D30 to 0x1D3F are carry-adds through Y. The low nibble k selects the radix n = 16 − k, so k = 0 means radix 16 and k = 15 means radix 1.
- R5: A carry-add forms s = mem + C. When s ≥ n it writes s − n and sets C. Otherwise it writes s and clears C. Z is set when the written nibble is zero.
- R6: After the write, the carry-add adds 1 to the pointer it used, wrapping from 0xFFFF to 0x0000. Memory is addressed by the pointer's low log2(DEPTH) bits. The pointer step has no effect on any flag.
- R7: A carry-add reads memory at the accepting edge. Busy is high for the next cycle. Memory, flags and pointer update on the following edge, and done pulses for one cycle after that edge.
- R8: Both operation families clear E and leave I unchanged.
- R9: Any other word that is presented while the unit is idle pulses illegal for one cycle after the accepting edge. It leaves registers, flags, pointers and memory unchanged.
- R10: When ld_en is high, instr_valid is low and the unit is idle, ld_sel writes one target. 0 writes A and 1 writes B, both from ld_data[3:0]. 2 writes X and 3 writes Y. 4 writes the flags as {E,I,C,Z} from ld_data[3:0]. 5 writes memory at ld_addr from ld_data[3:0]. Codes 6 and 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 13 | Instruction word |
| ld_en | input | 1 | Preload strobe |
| ld_sel | input | 3 | Preload target code |
| ld_addr | input | AW | Preload memory address |
| ld_data | input | PW | Preload value |
| peek_addr | input | AW | Memory peek address |
| peek_data | output | DW | Nibble at peek_addr |
| reg_a | output | DW | Accumulator A |
| reg_b | output | DW | Accumulator B |
| ptr_x | output | PW | Pointer X |
| ptr_y | output | PW | Pointer Y |
| flag_e | output | 1 | E flag |
| flag_i | output | 1 | I flag |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| busy | output | 1 | Carry-add writeback pending |
| done | output | 1 | Operation completed pulse |
| illegal | output | 1 | Unrecognised word pulse |

## Verification
The assertions assume that no instruction and no preload arrive while busy is high, and that preloads are never presented in the same cycle as an instruction. Without those limits, the checks that pointers and flags hold across an illegal word or a writeback would not hold. The bench drives every instruction and every preload through tasks that wait for busy to fall before returning. It holds instr_valid and ld_en mutually exclusive, so the random mix of preloads, legal words and arbitrary 13-bit words stays inside those limits.

// File: rtl/nib_pkg.sv
// Shared widths and types for the nibble radix execution unit.
// Assumes a 4-bit data path and 13-bit instruction words.
package nib_pkg;
    localparam int DW = 4;
    localparam int IW = 13;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_RADD = 2'd1,
        OPK_CADD = 2'd2,
        OPK_BAD  = 2'd3
    } op_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } exec_state_e;

    typedef enum logic [2:0] {
        LD_A    = 3'd0,
        LD_B    = 3'd1,
        LD_X    = 3'd2,
        LD_Y    = 3'd3,
        LD_FLG  = 3'd4,
        LD_MEM  = 3'd5
    } ld_target_e;
endpackage

// File: rtl/nib_decode.sv
// Instruction classifier: splits a 13-bit word into register-add,
// carry-add or unrecognised, and extracts operand selects and radix code.
// Assumes the caller qualifies the result with its own valid strobe.
module nib_decode
    import nib_pkg::*;
(
    input  logic [IW-1:0] instr,
    output op_kind_e      kind,
    output logic          dst_b,
    output logic          src_b,
    output logic          use_y,
    output logic [3:0]    radix_k
);
    // Classify the word by its fixed high bits.
    always_comb begin
        if (instr[12:3] == 10'b11_0010_1110)
            kind = OPK_RADD;
        else if (instr[12:6] == 7'b1110100 && instr[4])
            kind = OPK_CADD;
        else
            kind = OPK_BAD;
    end

    assign dst_b   = instr[2];
    assign src_b   = instr[1];
    assign use_y   = instr[5];
    assign radix_k = instr[3:0];
endmodule

// File: rtl/nib_radix_add.sv
// Adds a carry-in to a nibble and folds the sum into radix n = 16 - k.
// Assumes k = 0 stands for radix 16; purely combinational.
module nib_radix_add
    import nib_pkg::*;
(
    input  logic [DW-1:0] din,
    input  logic          cin,
    input  logic [3:0]    k,
    output logic [DW-1:0] dout,
    output logic          cout,
    output logic          zero
);
    logic [DW:0] sum;
    logic [DW:0] radix;
    logic [DW:0] folded;

    // Raw sum, radix and conditional subtraction.
    always_comb begin
        sum    = {1'b0, din} + {{DW{1'b0}}, cin};
        radix  = (DW+1)'(16) - {1'b0, k};
        cout   = (sum >= radix);
        folded = cout ? (sum - radix) : sum;
        dout   = folded[DW-1:0];
        zero   = (dout == '0);
    end
endmodule

// File: rtl/nib_datamem.sv
// Nibble-wide data memory: one write port, one registered read port,
// one combinational peek port. Contents are not reset.
module nib_datamem #(
    parameter int DEPTH = 16,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    logic [DW-1:0] cells [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Registered read for the carry-add operand.
    always_ff @(posedge clk) begin
        if (re) rdata <= cells[raddr];
    end

    assign pdata = cells[paddr];
endmodule

// File: rtl/nib_radix_exec.sv
// Top of the nibble execution unit: register add in one cycle, memory
// carry-add with radix fold in two (read, then write and pointer step).
// Assumes no instruction or preload is presented while busy is high.
module nib_radix_exec
    import nib_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr,
    input  logic          ld_en,
    input  logic [2:0]    ld_sel,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] ld_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b,
    output logic [PW-1:0] ptr_x,
    output logic [PW-1:0] ptr_y,
    output logic          flag_e,
    output logic          flag_i,
    output logic          flag_c,
    output logic          flag_z,
    output logic          busy,
    output logic          done,
    output logic          illegal
);
    exec_state_e   state;
    op_kind_e      kind;
    logic          dst_b, src_b, use_y;
    logic [3:0]    radix_k;
    logic          wb_y;
    logic [3:0]    wb_k;
    logic          accept, take_ld;
    logic [DW-1:0] rd_nib, fold_nib, src_val, dst_val;
    logic          fold_c, fold_z;
    logic [DW:0]   radd_sum;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] rd_addr_sel;

    nib_decode u_dec (
        .instr   (instr),
        .kind    (kind),
        .dst_b   (dst_b),
        .src_b   (src_b),
        .use_y   (use_y),
        .radix_k (radix_k)
    );

    nib_radix_add u_fold (
        .din  (rd_nib),
        .cin  (flag_c),
        .k    (wb_k),
        .dout (fold_nib),
        .cout (fold_c),
        .zero (fold_z)
    );

    nib_datamem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (accept && kind == OPK_CADD),
        .raddr (rd_addr_sel),
        .rdata (rd_nib),
        .paddr (peek_addr),
        .pdata (peek_data)
    );

    // Handshake qualifiers, operand selection and memory write steering.
    always_comb begin
        accept      = (state == ST_IDLE) && instr_valid;
        take_ld     = (state == ST_IDLE) && !instr_valid && ld_en;
        rd_addr_sel = use_y ? ptr_y[AW-1:0] : ptr_x[AW-1:0];
        src_val     = src_b ? reg_b : reg_a;
        dst_val     = dst_b ? reg_b : reg_a;
        radd_sum    = {1'b0, dst_val} + {1'b0, src_val};
        if (state == ST_WB) begin
            mem_we    = 1'b1;
            mem_waddr = wb_y ? ptr_y[AW-1:0] : ptr_x[AW-1:0];
            mem_wdata = fold_nib;
        end else begin
            mem_we    = take_ld && ld_sel == LD_MEM;
            mem_waddr = ld_addr;
            mem_wdata = ld_data[DW-1:0];
        end
    end

    assign busy = (state == ST_WB);

    // Sequencer plus architectural register, pointer and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            reg_a   <= '0;
            reg_b   <= '0;
            ptr_x   <= '0;
            ptr_y   <= '0;
            flag_e  <= 1'b0;
            flag_i  <= 1'b0;
            flag_c  <= 1'b0;
            flag_z  <= 1'b0;
            wb_y    <= 1'b0;
            wb_k    <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            if (state == ST_WB) begin
                flag_c <= fold_c;
                flag_z <= fold_z;
                flag_e <= 1'b0;
                if (wb_y) ptr_y <= ptr_y + 1'b1;
                else      ptr_x <= ptr_x + 1'b1;
                state  <= ST_IDLE;
                done   <= 1'b1;
            end else if (accept) begin
                unique case (kind)
                    OPK_RADD: begin
                        if (dst_b) reg_b <= radd_sum[DW-1:0];
                        else       reg_a <= radd_sum[DW-1:0];
                        flag_c <= radd_sum[DW];
                        flag_z <= (radd_sum[DW-1:0] == '0);
                        flag_e <= 1'b0;
                        done   <= 1'b1;
                    end
                    OPK_CADD: begin
                        wb_y  <= use_y;
                        wb_k  <= radix_k;
                        state <= ST_WB;
                    end
                    default: illegal <= 1'b1;
                endcase
            end else if (take_ld) begin
                case (ld_sel)
                    LD_A:   reg_a <= ld_data[DW-1:0];
                    LD_B:   reg_b <= ld_data[DW-1:0];
                    LD_X:   ptr_x <= ld_data;
                    LD_Y:   ptr_y <= ld_data;
                    LD_FLG: {flag_e, flag_i, flag_c, flag_z} <= ld_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    // R7
    wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && done));

    // R3
    radd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == OPK_RADD) |=> (done && !busy));

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(reg_a) && $stable(reg_b) && $stable(ptr_x) &&
                     $stable(ptr_y) && $stable(flag_c) && $stable(flag_z) &&
                     $stable(flag_e) && $stable(flag_i)));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb_y) |=> (ptr_x == $past(ptr_x) + 1'b1 && $stable(ptr_y)));

    // R8
    e_clear_i_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flag_e && $stable(flag_i)));
endmodule

// File: tb/nib_radix_exec_tb.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the unit on every falling edge, plus directed checks.
module nib_radix_exec_tb;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int AW     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [12:0]   instr = '0;
    logic          ld_en = 1'b0;
    logic [2:0]    ld_sel = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0]   ld_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [3:0]    peek_data, reg_a, reg_b;
    logic [15:0]   ptr_x, ptr_y;
    logic          flag_e, flag_i, flag_c, flag_z, busy, done, illegal;

    nib_radix_exec #(.DEPTH(DEPTH), .PW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data), .reg_a(reg_a),
        .reg_b(reg_b), .ptr_x(ptr_x), .ptr_y(ptr_y), .flag_e(flag_e),
        .flag_i(flag_i), .flag_c(flag_c), .flag_z(flag_z), .busy(busy),
        .done(done), .illegal(illegal)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int m_a, m_b, m_x, m_y, m_e, m_i, m_c, m_z;
    int m_busy, m_done, m_ill, m_wy, m_k;
    int m_mem [DEPTH];
    bit started = 0;
    bit mem_known = 0;
    bit hold_peek = 0;
    int hold_addr = 0;
    int rot = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances one step per rising edge.
    always @(posedge clk) begin
        int s, n, adr, op;
        started = 1;
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_x = 0; m_y = 0;
            m_e = 0; m_i = 0; m_c = 0; m_z = 0;
            m_busy = 0; m_done = 0; m_ill = 0; m_wy = 0; m_k = 0;
        end else begin
            m_done = 0; m_ill = 0;
            if (m_busy == 1) begin
                adr = (m_wy == 1 ? m_y : m_x) % DEPTH;
                s = m_mem[adr] + m_c;
                n = 16 - m_k;
                if (s >= n) begin m_mem[adr] = s - n; m_c = 1; end
                else        begin m_mem[adr] = s;     m_c = 0; end
                m_z = (m_mem[adr] == 0) ? 1 : 0;
                m_e = 0;
                if (m_wy == 1) m_y = (m_y + 1) % 65536;
                else           m_x = (m_x + 1) % 65536;
                m_busy = 0; m_done = 1;
            end else if (instr_valid) begin
                op = int'(instr);
                if (op >= 'h1970 && op <= 'h1977) begin
                    s = (((op >> 1) & 1) == 1 ? m_b : m_a) +
                        (((op >> 2) & 1) == 1 ? m_b : m_a);
                    if (((op >> 2) & 1) == 1) m_b = s % 16; else m_a = s % 16;
                    m_c = (s > 15) ? 1 : 0;
                    m_z = (s % 16 == 0) ? 1 : 0;
                    m_e = 0; m_done = 1;
                end else if ((op >= 'h1D10 && op <= 'h1D1F) ||
                             (op >= 'h1D30 && op <= 'h1D3F)) begin
                    m_wy = (op >= 'h1D30) ? 1 : 0;
                    m_k = op % 16;
                    m_busy = 1;
                end else begin
                    m_ill = 1;
                end
            end else if (ld_en) begin
                case (int'(ld_sel))
                    0: m_a = int'(ld_data) % 16;
                    1: m_b = int'(ld_data) % 16;
                    2: m_x = int'(ld_data);
                    3: m_y = int'(ld_data);
                    4: begin
                        m_e = int'(ld_data[3]); m_i = int'(ld_data[2]);
                        m_c = int'(ld_data[1]); m_z = int'(ld_data[0]);
                    end
                    5: m_mem[int'(ld_addr)] = int'(ld_data) % 16;
                    default: ;
                endcase
            end
        end
    end

    // Cycle comparison on every falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R1/R2 reg_a", int'(reg_a), m_a);
            chk("R2 reg_b", int'(reg_b), m_b);
            chk("R6 ptr_x", int'(ptr_x), m_x);
            chk("R6 ptr_y", int'(ptr_y), m_y);
            chk("R8 flag_e", int'(flag_e), m_e);
            chk("R8 flag_i", int'(flag_i), m_i);
            chk("R5 flag_c", int'(flag_c), m_c);
            chk("R5 flag_z", int'(flag_z), m_z);
            chk("R7 busy", int'(busy), m_busy);
            chk("R3 done", int'(done), m_done);
            chk("R9 illegal", int'(illegal), m_ill);
            if (mem_known)
                chk("R5 memory", int'(peek_data), m_mem[int'(peek_addr)]);
            rot = (rot + 1) % DEPTH;
            peek_addr = AW'(hold_peek ? hold_addr : rot);
        end
    end

    task automatic run_op(input logic [12:0] op);
        @(negedge clk);
        instr_valid = 1'b1; instr = op;
        @(negedge clk);
        instr_valid = 1'b0;
        if (busy) @(negedge clk);
    endtask

    task automatic preload(input int sel, input int adr, input int val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'(sel); ld_addr = AW'(adr); ld_data = 16'(val);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic mem_is(input string tag, input int adr, input int exp);
        hold_addr = adr; hold_peek = 1;
        @(negedge clk);
        @(negedge clk);
        chk(tag, int'(peek_data), exp);
        hold_peek = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 ptr_x", int'(ptr_x), 0);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) preload(5, i, (i * 7) % 16);
        mem_known = 1;

        // R2: 9 + 8 into A wraps to 1 with carry
        preload(0, 0, 9);
        preload(1, 0, 8);
        run_op(13'h1972);
        chk("R2 A+=B result", int'(reg_a), 1);
        chk("R2 A+=B carry", int'(flag_c), 1);
        chk("R3 done pulse", int'(done), 1);
        // R2: bit 0 ignored, B+=B 8+8 = 0, Z set
        run_op(13'h1977);
        chk("R2 B+=B zero", int'(flag_z), 1);

        // R4 R5 R8: radix 10, mem 9 + C 1 -> 0 with carry
        preload(4, 0, 'b1110);
        preload(2, 0, 3);
        preload(5, 3, 9);
        run_op(13'h1D16);
        chk("R5 decimal carry", int'(flag_c), 1);
        chk("R5 zero on write", int'(flag_z), 1);
        chk("R6 X stepped", int'(ptr_x), 4);
        chk("R8 E cleared", int'(flag_e), 0);
        chk("R8 I kept", int'(flag_i), 1);
        mem_is("R5 decimal wrap", 3, 0);

        // R6: Y wraps, radix 16, no carry in
        preload(4, 0, 0);
        preload(3, 0, 'hFFFF);
        preload(5, 15, 5);
        run_op(13'h1D30);
        chk("R6 Y wrap", int'(ptr_y), 0);
        chk("R6 no carry", int'(flag_c), 0);
        mem_is("R4 radix 16 store", 15, 5);

        // R4: radix 1 with carry in gives 0 and carry
        preload(4, 0, 'b0010);
        preload(2, 0, 7);
        preload(5, 7, 0);
        run_op(13'h1D1F);
        chk("R4 radix 1 carry", int'(flag_c), 1);
        mem_is("R4 radix 1 store", 7, 0);

        // R9: unrecognised word
        run_op(13'h1D20);
        chk("R9 illegal pulse", int'(illegal), 1);
        chk("R9 ptr_x held", int'(ptr_x), 8);
        // R10: unused preload code writes nothing
        preload(6, 0, 'hF);
        chk("R10 code 6 no effect A", int'(reg_a), 1);

        // Mixed random traffic against the model
        for (int t = 0; t < 600; t++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 2)
                preload(int'($urandom % 8), int'($urandom % DEPTH), int'($urandom));
            else if (r < 4)
                run_op(13'h1970 + 13'($urandom % 8));
            else if (r < 7)
                run_op(13'h1D10 | 13'(($urandom % 2) << 5) | 13'($urandom % 16));
            else
                run_op(13'($urandom));
        end

        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule